// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block is a small clocked register that, on every rising clock edge, either keeps its contents, takes a new word from its parallel data input, or moves its contents one place in either direction. A two-bit mode code selects the operation. Each direction has its own serial fill input: one bit enters at the low end when the contents move toward the high end, and another enters at the high end when the contents move toward the low end.

A synchronous clear input zeroes the register on the next edge, whatever the mode is. The register bits appear directly on the output, and two extra serial-out taps repeat the top and bottom bits for neighbours that chain several registers. The width is a parameter with a default of four, and the behaviour below is specified for that value. The data pins are plain, level-sampled inputs with no handshake, because the register accepts a new operation on every edge and never stalls.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low, `q` is 0000, and it stays 0000 on the first edge after release if the mode is hold (00).
- R2: Mode 00 (hold) with `clr` low leaves `q` unchanged on the edge; for example, 0011 stays 0011.
- R3: Mode 01 (load) with `clr` low copies `par_in` into `q` on the edge, bit for bit; for example, 0011 becomes 0101 when `par_in` is 0101.
- R4: Mode 10 (shift up) with `clr` low sets each `q[i]` to the old `q[i-1]` and `q[0]` to `fill_up`; for example, 0011 with `fill_up`=1 becomes 0111.
- R5: Mode 11 (shift down) with `clr` low sets each `q[i]` to the old `q[i+1]` and `q[3]` to `fill_dn`; for example, 0011 with `fill_dn`=0 becomes 0001.
- R6: When `clr` is high, `q` becomes 0000 on the edge in every mode, and the data and fill inputs have no effect.
- R7: `msb_out` always equals `q[3]` and `lsb_out` always equals `q[0]`.
- R8: A fill input has no effect unless its own shift mode is selected: `fill_dn` is ignored in mode 10 and `fill_up` is ignored in mode 11, and both are ignored in modes 00 and 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register |
| clr | input | 1 | Synchronous clear, overrides the mode |
| mode | input | 2 | 00 hold, 01 load, 10 shift up, 11 shift down |
| par_in | input | 4 | Parallel load word |
| fill_up | input | 1 | Bit that enters `q[0]` when shifting up |
| fill_dn | input | 1 | Bit that enters `q[3]` when shifting down |
| q | output | 4 | Register contents |
| msb_out | output | 1 | Serial-out tap of `q[3]` |
| lsb_out | output | 1 | Serial-out tap of `q[0]` |

## Verification
The bench goes after the end bits of each shift. A design that swapped the two fill inputs, or that fed a fill bit into the wrong end, would put the wrong bit in `q[0]` or `q[3]` when the two fills are driven to opposite values. It also applies a clear in every mode with the data and fills held at ones. A clear placed below a mode in the priority order would then leave ones in the register. It also checks that a long run of shifts in one direction empties the register, and that the fill of the direction not selected has no effect. A design that mixed up the mode codes would show up in the fixed examples for each mode and in the random runs, where the result is compared with a model on every edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_LOAD = 2'b01,
    MODE_UP   = 2'b10,
    MODE_DOWN = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_cell.sv
// Next-state selector for one register bit.
module ushift_cell
  import ushift_pkg::*;
(
  input  mode_e mode,
  input  logic  cur,
  input  logic  par,
  input  logic  from_lo,
  input  logic  from_hi,
  output logic  nxt
);
  always_comb begin
    case (mode)
      MODE_HOLD: nxt = cur;
      MODE_LOAD: nxt = par;
      MODE_UP:   nxt = from_lo;
      MODE_DOWN: nxt = from_hi;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/ushift_bank.sv
// Storage flops with asynchronous reset and synchronous clear.
module ushift_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= d;
  end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         fill_up,
  input  logic         fill_dn,
  output logic [W-1:0] q,
  output logic         msb_out,
  output logic         lsb_out
);
  localparam int TOP = W - 1;

  mode_e        mode_sel;
  logic [W-1:0] lo_src;
  logic [W-1:0] hi_src;
  logic [W-1:0] next_q;

  assign mode_sel = mode_e'(mode);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo_edge
      assign lo_src[i] = fill_up;
    end else begin : g_lo_mid
      assign lo_src[i] = q[i-1];
    end
    if (i == TOP) begin : g_hi_edge
      assign hi_src[i] = fill_dn;
    end else begin : g_hi_mid
      assign hi_src[i] = q[i+1];
    end
    ushift_cell u_cell (
      .mode    (mode_sel),
      .cur     (q[i]),
      .par     (par_in[i]),
      .from_lo (lo_src[i]),
      .from_hi (hi_src[i]),
      .nxt     (next_q[i])
    );
  end

  ushift_bank #(.W(W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .d     (next_q),
    .q     (q)
  );

  assign msb_out = q[TOP];
  assign lsb_out = q[0];
endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic [1:0]   mode,
  input logic [W-1:0] par_in,
  input logic         fill_up,
  input logic         fill_dn,
  input logic [W-1:0] q
);
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  p_hold_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode == 2'b00) |=> $stable(q));

  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode == 2'b01) |=> (q == $past(par_in)));

  p_shift_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode == 2'b10) |=> (q == {$past(q[W-2:0]), $past(fill_up)}));

  p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode == 2'b11) |=> (q == {$past(fill_dn), $past(q[W-1:1])}));
endmodule

bind ushift_reg ushift_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr),
  .mode    (mode),
  .par_in  (par_in),
  .fill_up (fill_up),
  .fill_dn (fill_dn),
  .q       (q)
);

// File: tb/tb_ushift_reg.sv
`timescale 1ns/1ps
module tb_ushift_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] par_in = 4'h0;
  logic       fill_up = 1'b0;
  logic       fill_dn = 1'b0;
  logic [3:0] q;
  logic       msb_out, lsb_out;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] model = 4'h0;

  always #10 clk = ~clk;

  ushift_reg dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .par_in(par_in),
    .fill_up(fill_up), .fill_dn(fill_dn), .q(q),
    .msb_out(msb_out), .lsb_out(lsb_out)
  );

  function automatic logic [3:0] predict(logic [3:0] cur, logic c, logic [1:0] m,
                                         logic [3:0] p, logic e, logic f);
    if (c) return 4'h0;
    case (m)
      2'b00:   return cur;
      2'b01:   return p;
      2'b10:   return {cur[2:0], e};
      default: return {f, cur[3:1]};
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    compared++;
    if (q !== exp) begin
      mismatched++;
      $display("FAIL %s: q actual %b expected %b", req, q, exp);
    end
    compared++;
    if (msb_out !== exp[3] || lsb_out !== exp[0]) begin
      mismatched++;
      $display("FAIL R7: taps actual %b%b expected %b%b", msb_out, lsb_out, exp[3], exp[0]);
    end
  endtask

  // Drive at the falling edge, clock once, compare at the next falling edge.
  task automatic step(string req, logic c, logic [1:0] m, logic [3:0] p, logic e, logic f);
    clr = c; mode = m; par_in = p; fill_up = e; fill_dn = f;
    model = predict(model, c, m, p, e, f);
    @(posedge clk);
    @(negedge clk);
    check(req, model);
  endtask

  task automatic preset(logic [3:0] v);
    step("R3", 1'b0, 2'b01, v, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", 4'h0);
    rst_n = 1'b1;
    step("R1", 1'b0, 2'b00, 4'hF, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    preset(4'b0011);
    step("R2", 1'b0, 2'b00, 4'b0101, 1'b1, 1'b0);
    step("R2", 1'b0, 2'b00, 4'b1111, 1'b1, 1'b1);
    step("R8", 1'b0, 2'b00, 4'b0000, 1'b0, 1'b1);
  endtask

  task automatic t_load;
    preset(4'b0011);
    step("R3", 1'b0, 2'b01, 4'b0101, 1'b1, 1'b0);
    step("R3", 1'b0, 2'b01, 4'b1010, 1'b0, 1'b1);
    step("R8", 1'b0, 2'b01, 4'b1000, 1'b1, 1'b1);
  endtask

  task automatic t_shift_up;
    preset(4'b0011);
    step("R4", 1'b0, 2'b10, 4'b0101, 1'b1, 1'b0);
    if (q !== 4'b0111) begin
      compared++; mismatched++;
      $display("FAIL R4: example actual %b expected %b", q, 4'b0111);
    end else compared++;
    for (int k = 0; k < 4; k++) step("R4", 1'b0, 2'b10, 4'hF, 1'b0, 1'b1);
    step("R8", 1'b0, 2'b10, 4'h0, 1'b1, 1'b0);
  endtask

  task automatic t_shift_down;
    preset(4'b0011);
    step("R5", 1'b0, 2'b11, 4'b0101, 1'b1, 1'b0);
    if (q !== 4'b0001) begin
      compared++; mismatched++;
      $display("FAIL R5: example actual %b expected %b", q, 4'b0001);
    end else compared++;
    for (int k = 0; k < 4; k++) step("R5", 1'b0, 2'b11, 4'hF, 1'b1, 1'b0);
    step("R8", 1'b0, 2'b11, 4'h0, 1'b0, 1'b1);
  endtask

  task automatic t_clear;
    for (int m = 0; m < 4; m++) begin
      preset(4'b1011);
      step("R6", 1'b1, 2'(m), 4'hF, 1'b1, 1'b1);
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++)
      step("R8", ($urandom % 8) == 0, 2'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_load();
    t_shift_up();
    t_shift_down();
    t_clear();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule